// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the device-side logic of a small serial EEPROM that is reached over a three-wire link: a select line, a serial clock and a data input, with one data output. The three lines arrive from outside the chip. They are synchronised into a fast system clock, and the block finds serial clock edges from the synchronised samples. After a start bit, the block shifts in a two-bit operation code, an address and, for the write forms, a data word. It then reads, programs or erases words in an internal array, or changes the programming lock.

The array holds 64 words of 16 bits. The organisation input selects whether a host sees it as 64 sixteen-bit words or as 128 bytes. The block models the timed programming phase with a cycle counter, and each kind of operation has its own length. While that phase runs, the host can raise select and read the progress on the output line. The output is given as a value and a separate drive enable, so a pad can put the line into high impedance.

Top module: `uwire_eeprom_slave`

## Requirements
- R1: A command begins only at the first rising serial clock edge at which select and data-in are both high; earlier rising edges with data-in low do not change the block's behaviour.
- R2: The two bits after the start bit choose the operation. 10 reads, 01 writes a word and 11 erases a word. With 00, the two most significant address bits choose further: 11 unlocks programming, 00 locks it, 10 erases the whole array and 01 writes one value everywhere.
- R3: With the organisation input high, the address is 6 bits and data is 16 bits. With it low, the address is a 7-bit byte address and data is 8 bits. Byte address b lives in word b>>1: in bits 15:8 when b is odd, and in bits 7:0 when b is even.
- R4: An operation takes effect only after all of its bits have arrived. Clock edges and data-in after that point are ignored until select goes low.
- R5: A read drives one 0 bit at the rising edge that takes in the last address bit. After that, each rising edge drives the next data bit, most significant first. While select stays high, the following address is read with no gap, and the address wraps at the top of the array.
- R6: After reset, programming is locked. Erase, write, erase-all and write-all then leave the array unchanged and start no busy phase. The lock persists until an unlock command runs, and the unlock persists until a lock command runs. Reads work in both states.
- R7: After reset, every word reads as all ones. Erase sets a word to ones and write stores the given data. Erase-all sets every word to ones, and write-all stores the given value in every word.
- R8: Programming starts at the falling edge of select after a complete, unlocked programming command. It runs for BUSY_WORD, BUSY_ERAL or BUSY_WRAL system cycles, whatever select does during that time, and the array holds the new value once the phase ends.
- R9: If select is raised during a busy phase, the output is driven: 0 while busy and 1 once ready. The output drive is off after every falling edge of select, and at all times other than read data and this status.
- R10: Select low returns the command decoder to its idle state and discards any partly received command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Select line, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data input, asynchronous |
| org16_i | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| do_o | output | 1 | Serial output value |
| do_oe_o | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The assertions assume that the serial clock is slow enough for every level to last at least two system cycles. They also assume that data-in and select are stable around each rising serial edge, so that the synchronised samples match what the host meant. The bench drives each serial half period for six system cycles and changes data-in only while the serial clock is low. It changes select only while the serial clock is low, and it samples the output just before each falling serial edge. The organisation input is changed only while select is low and no busy phase is running.

// File: rtl/uwe_pkg.sv
package uwe_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_READ, ST_DONE} dec_st_e;
  typedef enum logic [1:0] {OP_ERASE_ONE, OP_WRITE_ONE, OP_ERASE_ALL, OP_WRITE_ALL} prog_op_e;
  localparam int WORD_W = 16;
endpackage

// File: rtl/uwe_sync.sv
module uwe_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= d_i[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/uwe_decoder.sv
module uwe_decoder
  import uwe_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                cs_rise_i,
  input  logic                sk_rise_i,
  input  logic                di_i,
  input  logic                org16_i,
  input  logic                busy_i,
  input  logic [WORD_W-1:0]   rd_data_i,
  output logic [ADDR_W:0]     rd_addr_o,
  output logic                wr_en_o,
  output logic                pend_o,
  output prog_op_e            pend_op_o,
  output logic [ADDR_W:0]     pend_addr_o,
  output logic [WORD_W-1:0]   pend_data_o,
  output dec_st_e             st_o,
  output logic                do_o,
  output logic                do_oe_o
);
  localparam int BA_W  = ADDR_W + 1;
  localparam int HDR_W = BA_W + 2;

  dec_st_e           st_q;
  logic [HDR_W-2:0]  hdr_q;
  logic [4:0]        cnt_q;
  logic [3:0]        bidx_q;
  logic [BA_W-1:0]   rd_addr_q, addr_q;
  logic [WORD_W-1:0] data_q;
  logic              wr_en_q, pend_q, oe_q, do_q, stat_q;
  prog_op_e          op_q;

  logic [HDR_W-1:0]  full;
  logic [1:0]        opc, qual;
  logic [BA_W-1:0]   baddr;
  logic              hdr_last, data_last, word_last;
  logic [3:0]        dmax;

  assign full      = {hdr_q, di_i};
  assign opc       = org16_i ? full[HDR_W-2 -: 2] : full[HDR_W-1 -: 2];
  assign qual      = org16_i ? full[ADDR_W-1 -: 2] : full[BA_W-1 -: 2];
  assign baddr     = org16_i ? {1'b0, full[ADDR_W-1:0]} : full[BA_W-1:0];
  assign dmax      = org16_i ? 4'd15 : 4'd7;
  assign hdr_last  = cnt_q == (org16_i ? 5'(HDR_W-2) : 5'(HDR_W-1));
  assign data_last = cnt_q[3:0] == dmax;
  assign word_last = bidx_q == dmax;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; hdr_q <= '0; cnt_q <= '0; bidx_q <= '0;
      rd_addr_q <= '0; addr_q <= '0; data_q <= '0; op_q <= OP_ERASE_ONE;
      wr_en_q <= 1'b0; pend_q <= 1'b0; oe_q <= 1'b0; do_q <= 1'b0; stat_q <= 1'b0;
    end else if (!cs_i) begin
      st_q <= ST_IDLE; pend_q <= 1'b0; oe_q <= 1'b0; stat_q <= 1'b0; cnt_q <= '0;
    end else begin
      if (cs_rise_i && busy_i) stat_q <= 1'b1;
      if (sk_rise_i) begin
        unique case (st_q)
          ST_IDLE: if (di_i && !busy_i) begin
            st_q <= ST_HDR; cnt_q <= '0; stat_q <= 1'b0;
          end
          ST_HDR: begin
            hdr_q <= full[HDR_W-2:0];
            cnt_q <= cnt_q + 5'd1;
            if (hdr_last) begin
              addr_q <= baddr;
              cnt_q  <= '0;
              unique case (opc)
                2'b10: begin
                  st_q <= ST_READ; rd_addr_q <= baddr; bidx_q <= '0;
                  oe_q <= 1'b1; do_q <= 1'b0;
                end
                2'b01: begin st_q <= ST_DATA; op_q <= OP_WRITE_ONE; end
                2'b11: begin st_q <= ST_DONE; op_q <= OP_ERASE_ONE; pend_q <= 1'b1; end
                default: begin
                  st_q <= ST_DONE;
                  unique case (qual)
                    2'b11: wr_en_q <= 1'b1;
                    2'b00: wr_en_q <= 1'b0;
                    2'b10: begin op_q <= OP_ERASE_ALL; pend_q <= 1'b1; end
                    default: begin op_q <= OP_WRITE_ALL; st_q <= ST_DATA; end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            data_q <= {data_q[WORD_W-2:0], di_i};
            cnt_q  <= cnt_q + 5'd1;
            if (data_last) begin pend_q <= 1'b1; st_q <= ST_DONE; end
          end
          ST_READ: begin
            do_q <= rd_data_i[dmax - bidx_q];
            if (word_last) begin
              bidx_q    <= '0;
              rd_addr_q <= org16_i ? {1'b0, rd_addr_q[ADDR_W-1:0] + 1'b1} : rd_addr_q + 1'b1;
            end else begin
              bidx_q <= bidx_q + 4'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o   = rd_addr_q;
  assign wr_en_o     = wr_en_q;
  assign pend_o      = pend_q;
  assign pend_op_o   = op_q;
  assign pend_addr_o = addr_q;
  assign pend_data_o = data_q;
  assign st_o        = st_q;
  assign do_oe_o     = oe_q | stat_q;
  assign do_o        = stat_q ? !busy_i : do_q;
endmodule

// File: rtl/uwe_prog_engine.sv
module uwe_prog_engine
  import uwe_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BUSY_WORD = 300,
  parameter int BUSY_ERAL = 600,
  parameter int BUSY_WRAL = 900
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  prog_op_e          op_i,
  input  logic [ADDR_W:0]   addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              org16_i,
  input  logic [ADDR_W:0]   rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BA_W  = ADDR_W + 1;
  localparam int MAXA  = BUSY_ERAL > BUSY_WORD ? BUSY_ERAL : BUSY_WORD;
  localparam int MAXB  = BUSY_WRAL > MAXA ? BUSY_WRAL : MAXA;
  localparam int TW    = $clog2(MAXB + 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [TW-1:0]     cnt_q;
  logic              busy_q, org_q;
  prog_op_e          op_q;
  logic [BA_W-1:0]   addr_q;
  logic [WORD_W-1:0] data_q;
  logic [ADDR_W-1:0] widx, ridx;
  logic [WORD_W-1:0] rword;

  assign widx = org_q ? addr_q[ADDR_W-1:0] : addr_q[BA_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      cnt_q <= '0; busy_q <= 1'b0; org_q <= 1'b1;
      op_q <= OP_ERASE_ONE; addr_q <= '0; data_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
          unique case (op_q)
            OP_ERASE_ALL: mem_q[i] <= '1;
            OP_WRITE_ALL: mem_q[i] <= org_q ? data_q : {data_q[7:0], data_q[7:0]};
            default: if (ADDR_W'(i) == widx) begin
              if (org_q) mem_q[i] <= (op_q == OP_ERASE_ONE) ? '1 : data_q;
              else if (addr_q[0]) mem_q[i][15:8] <= (op_q == OP_ERASE_ONE) ? 8'hff : data_q[7:0];
              else mem_q[i][7:0] <= (op_q == OP_ERASE_ONE) ? 8'hff : data_q[7:0];
            end
          endcase
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1; op_q <= op_i; addr_q <= addr_i; data_q <= data_i; org_q <= org16_i;
      unique case (op_i)
        OP_ERASE_ALL: cnt_q <= TW'(BUSY_ERAL - 1);
        OP_WRITE_ALL: cnt_q <= TW'(BUSY_WRAL - 1);
        default:      cnt_q <= TW'(BUSY_WORD - 1);
      endcase
    end
  end

  assign ridx      = org16_i ? rd_addr_i[ADDR_W-1:0] : rd_addr_i[BA_W-1:1];
  assign rword     = mem_q[ridx];
  assign rd_data_o = org16_i ? rword : (rd_addr_i[0] ? {8'h00, rword[15:8]} : {8'h00, rword[7:0]});
  assign busy_o    = busy_q;
endmodule

// File: rtl/uwire_eeprom_slave.sv
module uwire_eeprom_slave
  import uwe_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BUSY_WORD = 300,
  parameter int BUSY_ERAL = 600,
  parameter int BUSY_WRAL = 900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org16_i,
  output logic do_o,
  output logic do_oe_o
);
  logic [2:0]        sync_q;
  logic              cs_s, sk_s, di_s, cs_q, sk_q;
  logic              cs_fall, cs_rise, sk_rise;
  logic              busy, wr_en, pend;
  prog_op_e          pend_op;
  logic [ADDR_W:0]   pend_addr, rd_addr;
  logic [WORD_W-1:0] pend_data, rd_data;
  dec_st_e           dec_st;

  uwe_sync #(.W(3)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({cs_i, sk_i, di_i}), .q_o(sync_q)
  );
  assign {cs_s, sk_s, di_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b0; sk_q <= 1'b0;
    end else begin
      cs_q <= cs_s; sk_q <= sk_s;
    end
  end
  assign sk_rise = sk_s & ~sk_q;
  assign cs_rise = cs_s & ~cs_q;
  assign cs_fall = cs_q & ~cs_s;

  uwe_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_s), .cs_rise_i(cs_rise),
    .sk_rise_i(sk_rise), .di_i(di_s), .org16_i(org16_i), .busy_i(busy),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .wr_en_o(wr_en), .pend_o(pend),
    .pend_op_o(pend_op), .pend_addr_o(pend_addr), .pend_data_o(pend_data),
    .st_o(dec_st), .do_o(do_o), .do_oe_o(do_oe_o)
  );

  uwe_prog_engine #(
    .ADDR_W(ADDR_W), .BUSY_WORD(BUSY_WORD), .BUSY_ERAL(BUSY_ERAL), .BUSY_WRAL(BUSY_WRAL)
  ) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cs_fall & pend & wr_en),
    .op_i(pend_op), .addr_i(pend_addr), .data_i(pend_data), .org16_i(org16_i),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy)
  );
endmodule

// File: rtl/uwe_checker.sv
module uwe_checker
  import uwe_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    cs_s_i,
  input logic    cs_fall_i,
  input logic    busy_i,
  input logic    wr_en_i,
  input dec_st_e st_i,
  input logic    do_oe_i
);
  AST_OE_OFF_AFTER_CS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_s_i) |=> !do_oe_i); // R9
  AST_PROG_NEEDS_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> wr_en_i); // R6
  AST_PROG_STARTS_AT_CS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(cs_fall_i)); // R8
  AST_DEC_IDLE_WHEN_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s_i |=> (st_i == ST_IDLE)); // R10
endmodule

bind uwire_eeprom_slave uwe_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s_i(cs_s), .cs_fall_i(cs_fall),
  .busy_i(busy), .wr_en_i(wr_en), .st_i(dec_st), .do_oe_i(do_oe_o)
);

// File: tb/uwire_eeprom_slave_bench.sv
module uwire_eeprom_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org16 = 1'b1;
  logic do_w, do_oe;
  int checks = 0, fails = 0;
  logic [15:0] got [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  uwire_eeprom_slave u_uwire_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .org16_i(org16), .do_o(do_w), .do_oe_o(do_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int aw();
    return org16 ? 6 : 7;
  endfunction
  function automatic int dw();
    return org16 ? 16 : 8;
  endfunction

  task automatic bit_io(input logic b, output logic oe, output logic v);
    di = b;
    repeat (HP) @(negedge clk);
    sk = 1'b1;
    repeat (HP-1) @(negedge clk);
    oe = do_oe; v = do_w;
    @(negedge clk);
    sk = 1'b0;
  endtask

  task automatic send(input logic [31:0] val, input int n);
    logic oe, v;
    for (int i = n-1; i >= 0; i--) bit_io(val[i], oe, v);
  endtask

  task automatic cs_hi;
    cs = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_lo;
    cs = 1'b0; di = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic read_words(input int a, input int n, input int pre);
    logic oe, v;
    cs_hi;
    send(0, pre);
    send(3'b110, 3);
    send(a >> 1, aw()-1);
    bit_io(a[0], oe, v);
    check("R5 dummy zero driven", {30'd0, oe, v}, 32'h2);
    for (int w = 0; w < n; w++) begin
      got[w] = '0;
      for (int b = 0; b < dw(); b++) begin
        bit_io(1'b0, oe, v);
        got[w] = {got[w][14:0], v};
      end
    end
    cs_lo;
    check("R9 drive off after select low", {31'd0, do_oe}, 32'd0);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    cs_hi; send(3'b101, 3); send(a, aw()); send(d, dw()); cs_lo;
  endtask

  task automatic cmd00(input logic [1:0] q);
    cs_hi; send(3'b100, 3); send(32'(q) << (aw()-2), aw()); cs_lo;
  endtask

  task automatic poll(input string req);
    int n;
    cs = 1'b1;
    repeat (5) @(negedge clk);
    check({req, " busy status shows 0"}, {30'd0, do_oe, do_w}, 32'h2);
    n = 0;
    while (!(do_oe && do_w) && n < 5000) begin @(negedge clk); n++; end
    check({req, " ready seen"}, {31'd0, n < 5000}, 32'd1);
    cs_lo;
  endtask

  task automatic expect_idle(input string req);
    cs_hi;
    repeat (5) @(negedge clk);
    check(req, {31'd0, do_oe}, 32'd0);
    cs_lo;
  endtask

  task automatic t_reset;
    check("R9 drive off after reset", {31'd0, do_oe}, 32'd0);
    read_words(0, 1, 0);
    check("R7 reset content ones", got[0], 16'hffff);
  endtask

  task automatic t_locked;
    wr(3, 16'h1234);
    expect_idle("R6 locked write starts no busy phase");
    read_words(3, 1, 0);
    check("R6 locked write leaves word", got[0], 16'hffff);
  endtask

  task automatic t_write_seq;
    cmd00(2'b11);
    wr(3, 16'ha5c3);
    poll("R9 R8 write");
    read_words(3, 1, 0);
    check("R7 R2 write stores data", got[0], 16'ha5c3);
    wr(4, 16'h0f0f); poll("R8 write4");
    read_words(3, 2, 0);
    check("R5 sequential word0", got[0], 16'ha5c3);
    check("R5 sequential word1", got[1], 16'h0f0f);
    wr(63, 16'hbeef); poll("R8 write63");
    read_words(63, 2, 0);
    check("R5 wrap word0", got[0], 16'hbeef);
    check("R5 wrap to address 0", got[1], 16'hffff);
  endtask

  task automatic t_erase_extra;
    cs_hi; send(3'b111, 3); send(3, 6);
    send(3'b110, 3);
    cs_lo;
    poll("R8 erase");
    read_words(3, 2, 0);
    check("R7 erase sets ones", got[0], 16'hffff);
    check("R4 trailing bits ignored", got[1], 16'h0f0f);
  endtask

  task automatic t_prog_no_status;
    wr(4, 16'h1111);
    repeat (1000) @(negedge clk);
    read_words(4, 1, 0);
    check("R8 completes with select low", got[0], 16'h1111);
  endtask

  task automatic t_abort;
    cs_hi; send(3'b101, 3); send(3'b000, 3); cs_lo;
    expect_idle("R10 aborted command starts nothing");
    read_words(4, 1, 2);
    check("R10 word kept after abort", got[0], 16'h1111);
    check("R1 leading zero clocks ignored", got[0], 16'h1111);
  endtask

  task automatic t_all;
    cmd00(2'b10); poll("R8 erase all");
    read_words(4, 1, 0);
    check("R7 R2 erase all", got[0], 16'hffff);
    cs_hi; send(3'b100, 3); send(32'h10, 6); send(16'h5a5a, 16); cs_lo;
    poll("R8 write all");
    read_words(0, 1, 0);
    check("R7 R2 write all word0", got[0], 16'h5a5a);
    read_words(63, 1, 0);
    check("R7 write all word63", got[0], 16'h5a5a);
  endtask

  task automatic t_bytes;
    org16 = 1'b0;
    wr(5, 16'h003c); poll("R8 byte write");
    read_words(4, 2, 0);
    check("R3 byte 4 untouched", got[0], 16'h005a);
    check("R3 byte 5 written", got[1], 16'h003c);
    org16 = 1'b1;
    read_words(2, 1, 0);
    check("R3 odd byte in high lane", got[0], 16'h3c5a);
  endtask

  task automatic t_relock;
    cmd00(2'b00);
    wr(2, 16'h0000);
    expect_idle("R6 relocked write starts nothing");
    read_words(2, 1, 0);
    check("R6 relocked word kept, read works", got[0], 16'h3c5a);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_locked;
    t_write_seq;
    t_erase_extra;
    t_prog_no_status;
    t_abort;
    t_all;
    t_bytes;
    t_relock;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule